// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block guesses, for each decoded conditional branch, whether the branch will be taken. The guess uses no run-time history. A 2-bit configuration input selects one of four fixed rules:
- never taken;
- always taken;
- by direction: a backward branch is taken and a forward branch is not, judged from the sign of the offset;
- copy a single hint bit that the compiler placed in the instruction.

The guess is registered. It appears one cycle after the branch strobe, together with a valid flag.

A separate tally path scores the predictor. Later in the pipeline the branch resolves. The pipeline then presents a resolve strobe, the actual outcome, and the guess that was issued for that branch. If the two agree, a hit counter increments. If they differ, a miss counter increments. Both counters stop at all-ones. The tally path does not depend on the prediction path, so both may act in the same cycle.

Top module: `static_branch_predictor`

## Requirements
- R1: After a synchronous active-low reset, `pred_valid`, `pred_taken`, `hit_count` and `miss_count` are all zero.
- R2: `pred_valid` is high in the cycle after `br_valid` is high and low otherwise. While `br_valid` is low, `pred_taken` keeps its last value.
- R3: With `policy` = 2'b00, a branch is predicted not taken (`pred_taken` = 0).
- R4: With `policy` = 2'b01, a branch is predicted taken (`pred_taken` = 1).
- R5: With `policy` = 2'b10, the prediction equals the most significant bit of `br_offset`, which is the sign bit. A negative offset gives taken. A zero or positive offset gives not taken.
- R6: With `policy` = 2'b11, the prediction equals `br_hint`.
- R7: A cycle with `res_valid` high and `res_taken` equal to `res_guess` raises `hit_count` by one on the next cycle and leaves `miss_count` unchanged.
- R8: A cycle with `res_valid` high and `res_taken` differing from `res_guess` raises `miss_count` by one on the next cycle and leaves `hit_count` unchanged.
- R9: A counter at all-ones stays at all-ones when a further increment is requested.
- R10: While `res_valid` is low, both counters hold their values, whatever the prediction inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | A conditional branch is presented this cycle |
| br_offset | input | OFS_W | Signed branch displacement |
| br_hint | input | 1 | Compiler hint bit from the instruction |
| policy | input | 2 | Rule select: 00 never, 01 always, 10 direction, 11 hint |
| pred_taken | output | 1 | Registered guess, 1 = taken |
| pred_valid | output | 1 | The guess belongs to a branch strobed one cycle earlier |
| res_valid | input | 1 | A branch has resolved this cycle |
| res_taken | input | 1 | Actual outcome of the resolved branch |
| res_guess | input | 1 | Guess that was issued for the resolved branch |
| hit_count | output | CNT_W | Saturating count of correct guesses |
| miss_count | output | CNT_W | Saturating count of wrong guesses |

## Verification
A new branch prediction and a resolve for an older branch can occur in the same cycle. They have separate inputs and must not disturb each other. The stimulus drives both strobes independently at random on every cycle, with all four rules and random offsets and hints, and adds directed runs of back-to-back resolves that push each counter into saturation. Each cycle a bench model computes the expected guess, valid flag and both counts, and these are compared with the outputs one cycle after the inputs.

// File: rtl/sbp_pkg.sv
// Package sbp_pkg
// Shared encoding of the prediction rule select.
// The numeric codes are fixed because configuration logic drives them directly.
package sbp_pkg;
    typedef enum logic [1:0] {
        POL_NEVER     = 2'b00,
        POL_ALWAYS    = 2'b01,
        POL_DIRECTION = 2'b10,
        POL_HINT      = 2'b11
    } policy_e;
endpackage

// File: rtl/sbp_policy.sv
// Module sbp_policy
// Purely combinational: turns the selected static rule, the branch offset and
// the hint bit into a single taken guess.
// Assumes the offset is two's complement. Zero counts as forward.
module sbp_policy
    import sbp_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  policy_e          sel,
    input  logic [OFS_W-1:0] offset,
    input  logic             hint,
    output logic             guess
);
    logic backward;

    // Backward branch detection from the signed offset.
    always_comb backward = ($signed(offset) < 0);

    // Rule multiplexer.
    always_comb begin
        case (sel)
            POL_NEVER:     guess = 1'b0;
            POL_ALWAYS:    guess = 1'b1;
            POL_DIRECTION: guess = backward;
            POL_HINT:      guess = hint;
            default:       guess = 1'b0;
        endcase
    end
endmodule

// File: rtl/sbp_sat_counter.sv
// Module sbp_sat_counter
// Up counter that stops at all-ones and clears on synchronous active-low reset.
// Assumes the increment request lasts one cycle per event.
module sbp_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    // Counter register with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != MAX)
            count <= count + 1'b1;
    end

    // R9: a full counter never wraps.
    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAX) |=> (count == MAX));

    // R7 / R8: each accepted request adds exactly one.
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count != MAX) |=> (count == $past(count) + 1'b1));

    // R10: no request, no change.
    assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
endmodule

// File: rtl/sbp_tally.sv
// Module sbp_tally
// Scores resolved branches: one saturating counter for agreements and one for
// disagreements between the issued guess and the actual outcome.
// Assumes each resolved branch is presented for exactly one cycle.
module sbp_tally #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         res_valid,
    input  logic         res_taken,
    input  logic         res_guess,
    output logic [W-1:0] hit_count,
    output logic [W-1:0] miss_count
);
    localparam int NCNT = 2;
    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic [NCNT-1:0] inc;
    logic [W-1:0]    cnt [NCNT];

    // Sort each resolve event: index 0 counts agreements, index 1 counts disagreements.
    always_comb begin
        inc[0] = res_valid && (res_taken == res_guess);
        inc[1] = res_valid && (res_taken != res_guess);
    end

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        sbp_sat_counter #(.W(W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[i]),
            .count (cnt[i])
        );
    end

    assign hit_count  = cnt[0];
    assign miss_count = cnt[1];

    // R7: an agreement raises hits (or leaves them saturated) and never touches misses.
    assert_hit_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken == res_guess) |=>
        ($stable(miss_count) &&
         (hit_count == $past(hit_count) + 1'b1 || $past(hit_count) == MAX)));

    // R8: a disagreement raises misses (or leaves them saturated) and never touches hits.
    assert_miss_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken != res_guess) |=>
        ($stable(hit_count) &&
         (miss_count == $past(miss_count) + 1'b1 || $past(miss_count) == MAX)));

    // R10: with no resolve strobe, both counters hold.
    assert_tally_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> ($stable(hit_count) && $stable(miss_count)));
endmodule

// File: rtl/static_branch_predictor.sv
// Module static_branch_predictor
// Top level. Registers a static taken guess one cycle after each branch
// strobe and scores resolved branches in two saturating counters.
// Assumes synchronous active-low reset and a single clock domain.
module static_branch_predictor
    import sbp_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [OFS_W-1:0] br_offset,
    input  logic             br_hint,
    input  logic [1:0]       policy,
    output logic             pred_taken,
    output logic             pred_valid,
    input  logic             res_valid,
    input  logic             res_taken,
    input  logic             res_guess,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    policy_e sel;
    logic    guess;

    // Map the raw select onto the rule encoding.
    always_comb sel = policy_e'(policy);

    sbp_policy #(.OFS_W(OFS_W)) u_policy (
        .sel    (sel),
        .offset (br_offset),
        .hint   (br_hint),
        .guess  (guess)
    );

    // Output register: load the guess on a branch, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_taken <= 1'b0;
            pred_valid <= 1'b0;
        end else begin
            pred_valid <= br_valid;
            if (br_valid)
                pred_taken <= guess;
        end
    end

    sbp_tally #(.W(CNT_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid  (res_valid),
        .res_taken  (res_taken),
        .res_guess  (res_guess),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    // R2: the valid flag follows the strobe by one cycle.
    assert_valid_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> pred_valid);
    assert_valid_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> (!pred_valid && $stable(pred_taken)));

    // R3: never-taken rule.
    assert_never_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && policy == 2'b00) |=> !pred_taken);

    // R4: always-taken rule.
    assert_always_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && policy == 2'b01) |=> pred_taken);

    // R5: direction rule follows the offset sign bit.
    assert_direction_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && policy == 2'b10) |=> (pred_taken == $past(br_offset[OFS_W-1])));

    // R6: hint rule copies the hint bit.
    assert_hint_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && policy == 2'b11) |=> (pred_taken == $past(br_hint)));
endmodule

// File: tb/sim_static_branch_predictor.sv
module sim_static_branch_predictor;
    localparam int OFS_W = 16;
    localparam int CNT_W = 8;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             br_valid = 1'b0;
    logic [OFS_W-1:0] br_offset = '0;
    logic             br_hint = 1'b0;
    logic [1:0]       policy = 2'b00;
    logic             pred_taken, pred_valid;
    logic             res_valid = 1'b0;
    logic             res_taken = 1'b0;
    logic             res_guess = 1'b0;
    logic [CNT_W-1:0] hit_count, miss_count;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic             e_taken, e_valid;
    logic [CNT_W-1:0] e_hit, e_miss;
    string            tag_pred, tag_cnt;

    always #4 clk = ~clk;

    static_branch_predictor #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_offset(br_offset),
        .br_hint(br_hint), .policy(policy), .pred_taken(pred_taken),
        .pred_valid(pred_valid), .res_valid(res_valid), .res_taken(res_taken),
        .res_guess(res_guess), .hit_count(hit_count), .miss_count(miss_count)
    );

    // Expected guess from the requirement text.
    function automatic logic f_guess(input logic [1:0] p, input logic [OFS_W-1:0] o, input logic h);
        case (p)
            2'b00: return 1'b0;                // R3
            2'b01: return 1'b1;                // R4
            2'b10: return o[OFS_W-1];          // R5
            default: return h;                 // R6
        endcase
    endfunction

    function automatic string f_tag(input logic [1:0] p);
        case (p)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one cycle of inputs at a falling edge and update the model.
    task automatic drive(input logic bv, input logic [OFS_W-1:0] of, input logic h,
                         input logic [1:0] p, input logic rv, input logic rt, input logic rg);
        br_valid = bv; br_offset = of; br_hint = h; policy = p;
        res_valid = rv; res_taken = rt; res_guess = rg;
        e_valid = bv;
        if (bv) begin
            e_taken = f_guess(p, of, h);
            tag_pred = f_tag(p);
        end else begin
            tag_pred = "R2";
        end
        if (!rv) tag_cnt = "R10";
        else if (rt == rg) begin
            tag_cnt = (e_hit == CMAX) ? "R9" : "R7";
            if (e_hit != CMAX) e_hit = e_hit + 1'b1;
        end else begin
            tag_cnt = (e_miss == CMAX) ? "R9" : "R8";
            if (e_miss != CMAX) e_miss = e_miss + 1'b1;
        end
    endtask

    // Falling edge after the register update: compare against the model.
    task automatic settle_and_check();
        @(negedge clk);
        check("R2", pred_valid, e_valid);
        check(tag_pred, pred_taken, e_taken);
        check(tag_cnt, hit_count, e_hit);
        check(tag_cnt, miss_count, e_miss);
    endtask

    task automatic step(input logic bv, input logic [OFS_W-1:0] of, input logic h,
                        input logic [1:0] p, input logic rv, input logic rt, input logic rg);
        drive(bv, of, h, p, rv, rt, rg);
        settle_and_check();
    endtask

    initial begin
        void'($urandom(32'd2718));
        e_taken = 0; e_valid = 0; e_hit = '0; e_miss = '0;
        tag_pred = "R1"; tag_cnt = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state straight after reset.
        check("R1", pred_valid, 0);
        check("R1", pred_taken, 0);
        check("R1", hit_count, 0);
        check("R1", miss_count, 0);

        // Directed corner cases for the direction rule (R5) and the other rules.
        step(1, 16'h0000, 0, 2'b10, 0, 0, 0);   // R5 zero offset is forward
        step(1, 16'h8000, 0, 2'b10, 0, 0, 0);   // R5 most negative
        step(1, 16'h7FFF, 1, 2'b10, 0, 0, 0);   // R5 most positive
        step(1, 16'hFFFF, 0, 2'b10, 0, 0, 0);   // R5 minus one
        step(1, 16'h8000, 1, 2'b00, 0, 0, 0);   // R3
        step(1, 16'h0004, 0, 2'b01, 0, 0, 0);   // R4
        step(1, 16'h0004, 1, 2'b11, 0, 0, 0);   // R6
        step(1, 16'hFFF0, 0, 2'b11, 0, 0, 0);   // R6
        step(0, 16'hFFF0, 1, 2'b01, 0, 0, 0);   // R2 held value
        // Prediction and resolve in the same cycle.
        step(1, 16'hFF00, 0, 2'b10, 1, 1, 1);   // R7
        step(1, 16'h0100, 0, 2'b10, 1, 1, 0);   // R8

        // Random mix of all inputs.
        for (int i = 0; i < 3000; i++)
            step($urandom_range(0, 1), OFS_W'($urandom), $urandom_range(0, 1),
                 2'($urandom_range(0, 3)), $urandom_range(0, 1),
                 $urandom_range(0, 1), $urandom_range(0, 1));

        // Saturate both counters (R9), then idle with branches running (R10).
        for (int i = 0; i < 300; i++) step(1, OFS_W'($urandom), 0, 2'b01, 1, 0, 0);
        check("R9", hit_count, CMAX);
        for (int i = 0; i < 300; i++) step(0, 16'h0, 0, 2'b00, 1, 1, 0);
        check("R9", miss_count, CMAX);
        for (int i = 0; i < 20; i++) step(1, OFS_W'($urandom), 1, 2'b11, 0, 1, 1);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule